// File: doc/BRIEF.md
# Clamped Integral Period-Tracking Controller

This block closes the digital loop that holds a series-resonant inverter load at resonance. The loop acts on the inverter switching period rather than on its frequency. Each control step starts on a sample tick and always runs in the same order. The block pulses a start request to an external converter and waits for that converter to signal completion. It then reads the filtered phase measurement and forms an error about the quadrature point. It scales the error by a gain and adds the result to the period. Finally it clamps the new period between two limits and publishes it with a one-cycle strobe.

The measurement is a normalised unsigned value in which full scale stands for 1.0. Midscale (one half) means the capacitor and inverter voltages are 90 degrees apart, so the inverter current is in phase with its voltage. The gain is a signed fixed-point number, and the period limits come from the frequency ceiling and floor of the load. In a typical use the tick arrives every 200 µs. With a 100 MHz clock, limits of 1000 and 2000 counts give a 100 kHz ceiling and a 50 kHz floor.

Top module: `period_track_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is held at a clock edge, the period takes `perInit`, and both `convStart` and `periodValid` are low after that edge.
- R2: When the block is idle and `sampleTick` is sampled high, `convStart` goes high for exactly one cycle, starting with the next cycle.
- R3: After `convStart`, the block waits for any number of cycles until `convDone` is sampled high. The period does not change while it waits, and `convDone` is ignored in the cycle in which `convStart` is high.
- R4: The error is `convData` minus 2^(MEAS_W-1), taken as a signed value. A midscale sample (512 at the default width) leaves the period unchanged.
- R5: The step is gain × error divided by 2^GAIN_FRAC, with any fraction dropped toward zero. The gain is signed two's complement with GAIN_FRAC fraction bits.
- R6: Before it is added, the step is saturated to the range -STEP_LIM to +STEP_LIM.
- R7: The updated period is clamped so that it is no lower than `perMin` and no higher than `perMax`.
- R8: When `convDone` is sampled high at edge E, the new period appears at edge E+2. At that same edge `periodValid` goes high, and it stays high for one cycle only.
- R9: A `sampleTick` that arrives while a step is in progress has no effect. This covers the cycle of the start pulse, the wait, and the two compute cycles.
- R10: The period holds its value in every cycle that is not an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sampleTick | input | 1 | Requests one control step |
| convDone | input | 1 | Converter completion handshake |
| convData | input | MEAS_W | Normalised phase measurement |
| gain | input | GAIN_W | Signed integral gain, GAIN_FRAC fraction bits |
| perMin | input | PER_W | Lowest allowed period (frequency ceiling) |
| perMax | input | PER_W | Highest allowed period (frequency floor) |
| perInit | input | PER_W | Period loaded during reset |
| convStart | output | 1 | One-cycle start request to the converter |
| period | output | PER_W | Current inverter period |
| periodValid | output | 1 | One-cycle strobe marking a new period |

## Verification
On every cycle the embedded assertions check these properties:
- the start pulse lasts one cycle and only follows a tick;
- the strobes of a step come in order;
- the saturated step stays within its bound;
- a midscale error produces a zero step;
- the period never moves outside an update;
- every loaded period lies within the limits.

Only the bench scenarios can show that the arithmetic rounds toward zero rather than down. They also show that the clamp settles at each limit under repeated pushes, that a long converter wait is tolerated, and that ticks arriving during a step are dropped. The bench compares all outputs with its behavioural model on every cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_CALC,
    ST_LOAD
  } ctlState_e;

  typedef struct packed {
    logic capture;
    logic calc;
    logic load;
  } dpStrobe_t;

endpackage

// File: rtl/ptc_control.sv
module ptc_control
  import ptc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sampleTick,
  input  logic      convDone,
  output logic      convStart,
  output dpStrobe_t strobe
);

  ctlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (sampleTick) stateNext = ST_START;
      ST_START: stateNext = ST_WAIT;
      ST_WAIT:  if (convDone) stateNext = ST_CALC;
      ST_CALC:  stateNext = ST_LOAD;
      ST_LOAD:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign convStart      = (state == ST_START);
  assign strobe.capture = (state == ST_WAIT) && convDone;
  assign strobe.calc    = (state == ST_CALC);
  assign strobe.load    = (state == ST_LOAD);

  // R2
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |=> !convStart);

  // R2
  start_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convStart) |-> $past(sampleTick));

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  // R8
  capture_then_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> strobe.calc);

  // R8
  calc_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.calc |=> strobe.load);

  // R9
  busy_tick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleTick && (state == ST_WAIT)) |=> !convStart);

endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
#(
  parameter int MEAS_W    = 10,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 6,
  parameter int PER_W     = 16,
  parameter int STEP_LIM  = 300
)(
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [MEAS_W-1:0] convData,
  input  logic [GAIN_W-1:0] gain,
  input  logic [PER_W-1:0]  perMin,
  input  logic [PER_W-1:0]  perMax,
  input  logic [PER_W-1:0]  perInit,
  output logic [PER_W-1:0]  period,
  output logic              periodValid
);

  localparam int ERR_W  = MEAS_W + 1;
  localparam int PROD_W = ERR_W + GAIN_W;
  localparam int STEP_W = $clog2(STEP_LIM + 1) + 1;
  localparam int SUM_W  = PER_W + 2;

  localparam logic signed [ERR_W-1:0]  HALF       = ERR_W'(1) <<< (MEAS_W - 1);
  localparam logic signed [PROD_W-1:0] ROUND_BIAS = PROD_W'((1 << GAIN_FRAC) - 1);
  localparam logic signed [PROD_W-1:0] STEP_HI    = PROD_W'(STEP_LIM);
  localparam logic signed [PROD_W-1:0] STEP_LO    = -PROD_W'(STEP_LIM);

  logic signed [ERR_W-1:0]  errReg;
  logic signed [PROD_W-1:0] prodFull, prodBiased, quot;
  logic signed [STEP_W-1:0] stepSat, stepReg;
  logic signed [SUM_W-1:0]  sumWide, minWide, maxWide;
  logic [PER_W-1:0]         perClamped;

  // error about the quadrature point
  always_ff @(posedge clk) begin
    if (!rst_n)              errReg <= '0;
    else if (strobe.capture) errReg <= $signed({1'b0, convData}) - HALF;
  end

  // gain product, truncation toward zero, saturation
  assign prodFull   = $signed({{GAIN_W{errReg[ERR_W-1]}}, errReg}
                            * {{ERR_W{gain[GAIN_W-1]}}, gain});
  assign prodBiased = prodFull + ((prodFull < 0) ? ROUND_BIAS : '0);
  assign quot       = prodBiased >>> GAIN_FRAC;

  always_comb begin
    if (quot > STEP_HI)      stepSat = STEP_W'(STEP_LIM);
    else if (quot < STEP_LO) stepSat = -STEP_W'(STEP_LIM);
    else                     stepSat = quot[STEP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           stepReg <= '0;
    else if (strobe.calc) stepReg <= stepSat;
  end

  // integrate and clamp
  assign sumWide = $signed({2'b00, period})
                 + $signed({{(SUM_W-STEP_W){stepReg[STEP_W-1]}}, stepReg});
  assign minWide = $signed({2'b00, perMin});
  assign maxWide = $signed({2'b00, perMax});

  always_comb begin
    if (sumWide < minWide)      perClamped = perMin;
    else if (sumWide > maxWide) perClamped = perMax;
    else                        perClamped = sumWide[PER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period      <= perInit;
      periodValid <= 1'b0;
    end else begin
      periodValid <= strobe.load;
      if (strobe.load) period <= perClamped;
    end
  end

  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepReg <= STEP_W'(STEP_LIM)) && (stepReg >= -STEP_W'(STEP_LIM)));

  // R4
  zero_err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.calc && (errReg == '0)) |=> (stepReg == '0));

  // R7
  clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> ((period >= $past(perMin)) && (period <= $past(perMax))));

  // R10
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(period));

endmodule

// File: rtl/period_track_ctrl.sv
module period_track_ctrl
  import ptc_pkg::*;
#(
  parameter int MEAS_W    = 10,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 6,
  parameter int PER_W     = 16,
  parameter int STEP_LIM  = 300
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleTick,
  input  logic              convDone,
  input  logic [MEAS_W-1:0] convData,
  input  logic [GAIN_W-1:0] gain,
  input  logic [PER_W-1:0]  perMin,
  input  logic [PER_W-1:0]  perMax,
  input  logic [PER_W-1:0]  perInit,
  output logic              convStart,
  output logic [PER_W-1:0]  period,
  output logic              periodValid
);

  dpStrobe_t strobe;

  ptc_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleTick (sampleTick),
    .convDone   (convDone),
    .convStart  (convStart),
    .strobe     (strobe)
  );

  ptc_datapath #(
    .MEAS_W    (MEAS_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC),
    .PER_W     (PER_W),
    .STEP_LIM  (STEP_LIM)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .convData    (convData),
    .gain        (gain),
    .perMin      (perMin),
    .perMax      (perMax),
    .perInit     (perInit),
    .period      (period),
    .periodValid (periodValid)
  );

endmodule

// File: tb/tb_period_track_ctrl.sv
module tb_period_track_ctrl;

  localparam int MEAS_W = 10, GAIN_W = 12, GAIN_FRAC = 6, PER_W = 16, STEP_LIM = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleTick = 1'b0, convDone = 1'b0;
  logic [MEAS_W-1:0] convData = '0;
  logic signed [GAIN_W-1:0] gain = 12'sd64;
  logic [PER_W-1:0] perMin = 16'd1000, perMax = 16'd2000, perInit = 16'd1500;
  logic convStart, periodValid;
  logic [PER_W-1:0] period;

  period_track_ctrl #(.MEAS_W(MEAS_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
                      .PER_W(PER_W), .STEP_LIM(STEP_LIM)) dut (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .convDone(convDone),
    .convData(convData), .gain(gain), .perMin(perMin), .perMax(perMax),
    .perInit(perInit), .convStart(convStart), .period(period),
    .periodValid(periodValid));

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  string curReq = "R1";
  bit checking = 1'b0;

  // behavioural reference
  int mPer = 1500, mPending = 0, mDelay = 0;
  bit mStart = 0, mValid = 0, mBusy = 0, mWait = 0;

  function automatic int refNext(int per, int data, int g);
    int err, step, sum;
    err  = data - (1 << (MEAS_W - 1));
    step = (g * err) / (1 << GAIN_FRAC);   // integer division truncates toward zero
    if (step > STEP_LIM)  step = STEP_LIM;
    if (step < -STEP_LIM) step = -STEP_LIM;
    sum = per + step;
    if (sum < int'(perMin)) sum = int'(perMin);
    else if (sum > int'(perMax)) sum = int'(perMax);
    return sum;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mPer = int'(perInit); mStart = 0; mValid = 0; mBusy = 0; mWait = 0; mDelay = 0;
    end else begin
      bit accept;
      accept = sampleTick && !mBusy;
      mValid = 0;
      if (mDelay > 0) begin
        mDelay--;
        if (mDelay == 0) begin mPer = mPending; mValid = 1; mBusy = 0; end
      end else if (accept) begin
        mStart = 1; mBusy = 1;
      end else if (mStart) begin
        mStart = 0; mWait = 1;
      end else if (mWait && convDone) begin
        mWait = 0; mDelay = 2;
        mPending = refNext(mPer, int'(convData), int'(gain));
      end
    end
  end

  task automatic report(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      report("convStart", int'(convStart), int'(mStart));
      report("periodValid", int'(periodValid), int'(mValid));
      report("period", int'(period), mPer);
    end
  end

  // one control step; waitCycles >= 0 extra cycles before convDone
  task automatic step(int data, int waitCycles, bit busyTicks);
    @(negedge clk) sampleTick = 1'b1;
    @(negedge clk) sampleTick = 1'b0;
    repeat (waitCycles + 1) begin
      @(negedge clk) sampleTick = busyTicks;
    end
    convData = MEAS_W'(data);
    convDone = 1'b1;
    @(negedge clk) begin convDone = 1'b0; sampleTick = busyTicks; end
    @(negedge clk) sampleTick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      miscompares++; vectors++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checking = 1'b1;                       // R1: reset state compared each cycle
    curReq = "R1";
    @(negedge clk);
    report("reset period", int'(period), 1500);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    curReq = "R4"; step(512, 0, 0);
    report("midscale leaves period", int'(period), 1500);
    curReq = "R2"; step(612, 0, 0);
    curReq = "R8"; step(412, 2, 0);
    curReq = "R5"; gain = 12'sd21; step(507, 0, 0);   // -105/64 -> -1
    report("toward zero negative", int'(period), 1499);
    step(517, 0, 0);                                   // +105/64 -> +1
    report("toward zero positive", int'(period), 1500);
    gain = -12'sd37; step(600, 1, 0);                  // -3256/64 -> -50
    curReq = "R6"; gain = 12'sd2047; step(1023, 0, 0);
    report("positive saturation", int'(period), 1750);
    step(0, 0, 0);
    curReq = "R7"; gain = 12'sd64;
    for (int i = 0; i < 6; i++) step(1023, 0, 0);
    report("upper clamp", int'(period), 2000);
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    report("lower clamp", int'(period), 1000);
    curReq = "R3"; step(700, 50, 0);
    curReq = "R9"; step(312, 6, 1);
    curReq = "R10"; repeat (20) @(negedge clk);
    curReq = "R1"; rst_n = 1'b0; perInit = 16'd1234;
    repeat (2) @(negedge clk);
    report("re-reset period", int'(period), 1234);
    rst_n = 1'b1;
    step(612, 0, 0);
    checking = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule